// File: doc/BRIEF.md
# Crossbar Slave-Port Arbiter

This block owns one slave port of a crossbar that links four masters to three slaves. Each master sends a request with a 32-bit address, a write flag, 64-bit write data and a last-beat marker. The arbiter picks one master as owner, passes that master's address, control and data to the slave, and sends the slave's read data and beat acceptance back. Every other requester stalls until the owner releases the port. A full crossbar is three copies of this block next to an address decoder that steers each master's request to the right copy.

Two arbitration schemes can be selected at run time. The first is a fixed order built from priority levels that software programs for each master. The second is a round-robin order in which the search starts just after the master granted most recently. Each master also has a boost input. While boost is high, that master is placed above every master that is not boosted. Configuration writes are staged and only take effect when no transaction is open. When no master is requesting, the port parks on the last owner.

Top module: `xbar_slot_arb`

## Requirements
- R1: After reset, with no request, `s_valid`, `m_gnt` and `m_ready` are all zero. The active scheme is fixed priority with every level at 0.
- R2: The slave sees the address, write flag, write data and last marker of the owning master only. `m_rdata` always equals `s_rdata`.
- R3: With `cfg_rr` = 0, the requester with the highest level wins. The level of master i is `cfg_prio[i*2 +: 2]`, and 3 is the highest. When levels are equal, the lower master index wins.
- R4: With `cfg_rr` = 1, the winner is the first requester found by searching upward from the last granted index plus one, wrapping from 3 back to 0.
- R5: In both schemes a requester with `m_boost` high beats every requester whose boost is low. Among boosted requesters, the rule of the current scheme decides.
- R6: A beat accepted with `s_last` = 0 locks the port to its owner. No other master is granted until a beat with `s_last` = 1 has been accepted.
- R7: A configuration write made while the port is locked takes effect at the first arbitration after the final beat. A write made while the port is unlocked takes effect from the next cycle.
- R8: With no request, `s_valid` is low and the port stays on the last owner. A new request, including one from the parked master, reaches `s_valid` in the same cycle with no added wait.
- R9: `m_ready` is high only for the owning master, and only in a cycle where the slave accepts the beat. Losing requesters see `m_ready` low.
- R10: While `s_ready` is low, no beat is accepted and every `m_ready` bit stays low. The owner's request stays presented to the slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rr | input | 1 | Scheme to stage: 0 fixed, 1 round-robin |
| cfg_prio | input | 8 | Levels to stage, 2 bits per master |
| m_req | input | 4 | Request per master |
| m_boost | input | 4 | Temporary priority raise per master |
| m_addr | input | 128 | Address per master, 32 bits each |
| m_we | input | 4 | Write flag per master |
| m_wdata | input | 256 | Write data per master, 64 bits each |
| m_last | input | 4 | Last-beat marker per master |
| m_gnt | output | 4 | One-hot owner while a request is presented |
| m_ready | output | 4 | Beat accepted, per master |
| m_rdata | output | 64 | Read data returned to the masters |
| s_valid | output | 1 | Request presented to the slave |
| s_addr | output | 32 | Address to the slave |
| s_we | output | 1 | Write flag to the slave |
| s_wdata | output | 64 | Write data to the slave |
| s_last | output | 1 | Last beat of the transaction |
| s_ready | input | 1 | Slave accepts the current beat |
| s_rdata | input | 64 | Read data from the slave |

## Verification
The bench builds the block with its defaults: four masters, 32-bit addresses, 64-bit data and 2-bit levels. Four levels are enough to set up a strict order across all masters and also a tie between two of them. Four masters let the round-robin pointer go all the way around, wrap from 3 back to 0, and skip masters that are not requesting. A mixed sequence of locked multi-beat transactions, boosted contenders and a configuration write made during a lock shows whether the old scheme or the new one was used at the hand-over.

// File: rtl/xarb_pkg.sv
// Shared definitions for the slave-port arbiter.
// Assumes the master count is a power of two (round-robin index wraps naturally).
package xarb_pkg;
    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_ROUND = 1'b1
    } arb_mode_e;
endpackage

// File: rtl/xarb_cfg.sv
// Configuration staging: writes land in a pending copy; the active copy
// follows it only when the caller says the port is at an arbitration point.
// Assumes apply is computed from the next-cycle lock state.
module xarb_cfg
    import xarb_pkg::*;
#(
    parameter int N_MST = 4,
    parameter int PW    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_rr,
    input  logic [N_MST*PW-1:0] wr_prio,
    input  logic               apply,
    output arb_mode_e          act_mode,
    output logic [N_MST*PW-1:0] act_prio
);
    arb_mode_e               pend_mode;
    logic [N_MST*PW-1:0]     pend_prio;
    arb_mode_e               next_mode;
    logic [N_MST*PW-1:0]     next_prio;

    // Pick the freshest staged value: this cycle's write or the held one.
    always_comb begin
        next_mode = wr_en ? arb_mode_e'(wr_rr) : pend_mode;
        next_prio = wr_en ? wr_prio : pend_prio;
    end

    // Hold the pending copy and copy it to the active set when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_mode <= ARB_FIXED;
            pend_prio <= '0;
            act_mode  <= ARB_FIXED;
            act_prio  <= '0;
        end else begin
            pend_mode <= next_mode;
            pend_prio <= next_prio;
            if (apply) begin
                act_mode <= next_mode;
                act_prio <= next_prio;
            end
        end
    end
endmodule

// File: rtl/xarb_pick.sv
// Winner selection, purely combinational.
// Fixed scheme: highest {boost, level}; ties go to the lowest index.
// Round-robin: first requester after last_id, boosted requesters only if any.
// With no request the winner is last_id (parking).
module xarb_pick
    import xarb_pkg::*;
#(
    parameter int N_MST = 4,
    parameter int PW    = 2,
    localparam int IW   = $clog2(N_MST)
) (
    input  logic [N_MST-1:0]    req,
    input  logic [N_MST-1:0]    boost,
    input  arb_mode_e           mode,
    input  logic [N_MST*PW-1:0] prio,
    input  logic [IW-1:0]       last_id,
    output logic [IW-1:0]       win_id
);
    logic [N_MST-1:0] hot;
    logic [IW-1:0]    fix_id;
    logic [IW-1:0]    rr_id;
    logic [PW:0]      best;
    logic [PW:0]      score;
    logic [IW-1:0]    idx;
    logic             found;

    // Restrict to boosted requesters when at least one is present.
    always_comb begin
        hot = ((req & boost) != '0) ? (req & boost) : req;
    end

    // Fixed order: scan from the top index down so ties settle on the lowest.
    always_comb begin
        fix_id = last_id;
        best   = '0;
        for (int i = N_MST - 1; i >= 0; i--) begin
            score = {boost[i], prio[i*PW +: PW]};
            if (req[i] && score >= best) begin
                best   = score;
                fix_id = IW'(i);
            end
        end
    end

    // Rotating order: search upward starting just after the last owner.
    always_comb begin
        rr_id = last_id;
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= N_MST; k++) begin
            idx = last_id + k[IW-1:0];
            if (!found && hot[idx]) begin
                rr_id = idx;
                found = 1'b1;
            end
        end
    end

    // Select between the two schemes.
    always_comb begin
        win_id = (mode == ARB_ROUND) ? rr_id : fix_id;
    end
endmodule

// File: rtl/xarb_route.sv
// Datapath steering: forwards the owner's request fields to the slave and
// spreads acceptance back as one-hot vectors.
module xarb_route #(
    parameter int N_MST = 4,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int IW   = $clog2(N_MST)
) (
    input  logic [IW-1:0]       owner,
    input  logic [N_MST-1:0]    m_req,
    input  logic [N_MST*AW-1:0] m_addr,
    input  logic [N_MST-1:0]    m_we,
    input  logic [N_MST*DW-1:0] m_wdata,
    input  logic [N_MST-1:0]    m_last,
    input  logic                s_ready,
    output logic                s_valid,
    output logic [AW-1:0]       s_addr,
    output logic                s_we,
    output logic [DW-1:0]       s_wdata,
    output logic                s_last,
    output logic [N_MST-1:0]    m_gnt,
    output logic [N_MST-1:0]    m_ready
);
    // Forward the owner's fields.
    always_comb begin
        s_valid = m_req[owner];
        s_addr  = m_addr[owner*AW +: AW];
        s_we    = m_we[owner];
        s_wdata = m_wdata[owner*DW +: DW];
        s_last  = m_last[owner];
    end

    // One decode slice per master for grant and acceptance.
    for (genvar g = 0; g < N_MST; g++) begin : g_dec
        always_comb begin
            m_gnt[g]   = s_valid && (owner == IW'(g));
            m_ready[g] = m_gnt[g] && s_ready;
        end
    end
endmodule

// File: rtl/xbar_slot_arb.sv
// One slave port of a crossbar: arbitration, transaction lock, parking.
// Assumes an owner keeps its request high until its last beat is accepted.
module xbar_slot_arb
    import xarb_pkg::*;
#(
    parameter int N_MST = 4,
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int PW    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_rr,
    input  logic [N_MST*PW-1:0] cfg_prio,
    input  logic [N_MST-1:0]    m_req,
    input  logic [N_MST-1:0]    m_boost,
    input  logic [N_MST*AW-1:0] m_addr,
    input  logic [N_MST-1:0]    m_we,
    input  logic [N_MST*DW-1:0] m_wdata,
    input  logic [N_MST-1:0]    m_last,
    output logic [N_MST-1:0]    m_gnt,
    output logic [N_MST-1:0]    m_ready,
    output logic [DW-1:0]       m_rdata,
    output logic                s_valid,
    output logic [AW-1:0]       s_addr,
    output logic                s_we,
    output logic [DW-1:0]       s_wdata,
    output logic                s_last,
    input  logic                s_ready,
    input  logic [DW-1:0]       s_rdata
);
    localparam int IW = $clog2(N_MST);

    logic [IW-1:0]       owner_q;
    logic [IW-1:0]       owner;
    logic [IW-1:0]       win_id;
    logic                lock_q;
    logic                lock_n;
    logic                beat;
    arb_mode_e           act_mode;
    logic [N_MST*PW-1:0] act_prio;

    xarb_cfg #(.N_MST(N_MST), .PW(PW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_rr    (cfg_rr),
        .wr_prio  (cfg_prio),
        .apply    (!lock_n),
        .act_mode (act_mode),
        .act_prio (act_prio)
    );

    xarb_pick #(.N_MST(N_MST), .PW(PW)) u_pick (
        .req     (m_req),
        .boost   (m_boost),
        .mode    (act_mode),
        .prio    (act_prio),
        .last_id (owner_q),
        .win_id  (win_id)
    );

    xarb_route #(.N_MST(N_MST), .AW(AW), .DW(DW)) u_route (
        .owner   (owner),
        .m_req   (m_req),
        .m_addr  (m_addr),
        .m_we    (m_we),
        .m_wdata (m_wdata),
        .m_last  (m_last),
        .s_ready (s_ready),
        .s_valid (s_valid),
        .s_addr  (s_addr),
        .s_we    (s_we),
        .s_wdata (s_wdata),
        .s_last  (s_last),
        .m_gnt   (m_gnt),
        .m_ready (m_ready)
    );

    // Owner is frozen while locked, otherwise the fresh winner.
    always_comb begin
        owner   = lock_q ? owner_q : win_id;
        beat    = s_valid && s_ready;
        lock_n  = beat ? !s_last : lock_q;
        m_rdata = s_rdata;
    end

    // Track the lock and remember the last master that moved a beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= 1'b0;
            owner_q <= '0;
        end else begin
            lock_q <= lock_n;
            if (beat) begin
                owner_q <= owner;
            end
        end
    end
endmodule

// File: rtl/xarb_chk.sv
// Port-level properties of the slave-port arbiter, bound to every instance.
module xarb_chk #(
    parameter int N_MST = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_MST-1:0] m_req,
    input logic [N_MST-1:0] m_gnt,
    input logic [N_MST-1:0] m_ready,
    input logic             s_valid,
    input logic             s_ready,
    input logic             s_last
);
    a_r2_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_gnt));

    a_r2_owner_requests: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |-> ((m_req & m_gnt) != '0));

    a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && !s_last) |=> ((m_gnt == $past(m_gnt)) || (m_gnt == '0)));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req == '0) |-> !s_valid);

    a_r9_ready_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ready & ~m_gnt) == '0);

    a_r10_wait_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !s_ready |-> (m_ready == '0));
endmodule

bind xbar_slot_arb xarb_chk #(.N_MST(N_MST)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_req   (m_req),
    .m_gnt   (m_gnt),
    .m_ready (m_ready),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_last  (s_last)
);

// File: tb/xbar_slot_arb_test.sv
module xbar_slot_arb_test;
    localparam int CLK_T = 10;
    localparam int N  = 4;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int PW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic            cfg_rr = 1'b0;
    logic [N*PW-1:0] cfg_prio = '0;
    logic [N-1:0]    m_req = '0;
    logic [N-1:0]    m_boost = '0;
    logic [N*AW-1:0] m_addr;
    logic [N-1:0]    m_we;
    logic [N*DW-1:0] m_wdata;
    logic [N-1:0]    m_last = '1;
    logic [N-1:0]    m_gnt;
    logic [N-1:0]    m_ready;
    logic [DW-1:0]   m_rdata;
    logic            s_valid;
    logic [AW-1:0]   s_addr;
    logic            s_we;
    logic [DW-1:0]   s_wdata;
    logic            s_last;
    logic            s_ready = 1'b1;
    logic [DW-1:0]   s_rdata = 64'h5A5A_0123_4567_A5A5;

    int nchk = 0;
    int nbad = 0;
    int expq[$];

    always #(CLK_T/2) clk = ~clk;

    xbar_slot_arb uut (.*);

    function automatic logic [AW-1:0] addr_of(int i);
        return 32'hA000_0000 + 32'(i) * 32'h100;
    endfunction
    function automatic logic [DW-1:0] data_of(int i);
        return {32'hD000_0000 + 32'(i), 32'(i) ^ 32'h00FF_00FF};
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin
            m_addr[i*AW +: AW]  = addr_of(i);
            m_wdata[i*DW +: DW] = data_of(i);
            m_we[i]             = i[0];
        end
    end

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every accepted beat must match the head of the queue (R2).
    always @(negedge clk) begin
        if (rst_n && s_valid && s_ready) begin
            if (expq.size() == 0) begin
                check("R2 unexpected beat", 128'(s_addr), 128'hFFFF);
            end else begin
                int e;
                e = expq.pop_front();
                check("R2 s_addr", 128'(s_addr), 128'(addr_of(e)));
                check("R2 s_wdata", 128'(s_wdata), 128'(data_of(e)));
                check("R2 s_we", 128'(s_we), 128'(e % 2));
            end
        end
    end

    // Driver: one cycle of requests; pushes the expected owner when a beat is accepted.
    task automatic beat(string req, logic [N-1:0] r, logic [N-1:0] b, logic lst, logic rdy, int exp);
        @(posedge clk); #1;
        m_req = r; m_boost = b; m_last = {N{lst}}; s_ready = rdy;
        if (rdy) expq.push_back(exp);
        @(negedge clk);
        check({req, " gnt"}, 128'(m_gnt), 128'(4'b1 << exp));
        check({req, " R9 ready"}, 128'(m_ready), rdy ? 128'(4'b1 << exp) : 128'h0);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        m_req = '0; m_boost = '0; m_last = '1; s_ready = 1'b1;
    endtask

    task automatic write_cfg(logic rr, logic [N*PW-1:0] p);
        @(posedge clk); #1;
        m_req = '0; cfg_we = 1'b1; cfg_rr = rr; cfg_prio = p;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    initial begin
        #(CLK_T * 20000);
        nbad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check("R1 s_valid", 128'(s_valid), 0);
        check("R1 m_gnt", 128'(m_gnt), 0);
        check("R1 m_ready", 128'(m_ready), 0);
        check("R2 rdata", 128'(m_rdata), 128'(s_rdata));
        // R1/R3: all levels zero, tie -> lowest index
        beat("R1 R3 tie", 4'b1111, 4'b0, 1, 1, 0);
        beat("R3 tie12", 4'b0110, 4'b0, 1, 1, 1);
        idle();
        // R3: levels m0=0 m1=1 m2=3 m3=2
        write_cfg(1'b0, 8'b10_11_01_00);
        beat("R3 top", 4'b1111, 4'b0, 1, 1, 2);
        beat("R3 second", 4'b1011, 4'b0, 1, 1, 3);
        beat("R3 third", 4'b0011, 4'b0, 1, 1, 1);
        // R5: boost beats higher level in fixed scheme
        beat("R5 fixed boost", 4'b0111, 4'b0001, 1, 1, 0);
        idle();
        // R4: round robin from last owner 0
        write_cfg(1'b1, 8'b10_11_01_00);
        beat("R4 rr a", 4'b1111, 4'b0, 1, 1, 1);
        beat("R4 rr b", 4'b1111, 4'b0, 1, 1, 2);
        beat("R4 rr c", 4'b1111, 4'b0, 1, 1, 3);
        beat("R4 rr wrap", 4'b1111, 4'b0, 1, 1, 0);
        beat("R4 rr skip a", 4'b1010, 4'b0, 1, 1, 1);
        beat("R4 rr skip b", 4'b1010, 4'b0, 1, 1, 3);
        // R5: boost in round robin
        beat("R5 rr boost", 4'b1111, 4'b0100, 1, 1, 2);
        // R6: locked transaction is not pre-empted by a boosted master
        beat("R6 first", 4'b0001, 4'b0, 0, 1, 0);
        beat("R6 mid", 4'b0011, 4'b0010, 0, 1, 0);
        beat("R6 end", 4'b0011, 4'b0010, 1, 1, 0);
        beat("R6 after", 4'b0010, 4'b0, 1, 1, 1);
        beat("R4 rr to2", 4'b0100, 4'b0, 1, 1, 2);
        // R7: write during lock (fixed, m3 level 3) applies after the last beat
        beat("R7 open", 4'b0001, 4'b0, 0, 1, 0);
        cfg_we = 1'b1; cfg_rr = 1'b0; cfg_prio = 8'b11_00_00_00;
        beat("R7 mid", 4'b1011, 4'b0, 0, 1, 0);
        cfg_we = 1'b0;
        beat("R7 end", 4'b1011, 4'b0, 1, 1, 0);
        beat("R7 new scheme", 4'b1010, 4'b0, 1, 1, 3);
        // R10: slave wait holds the request, no ready
        beat("R10 wait", 4'b0100, 4'b0, 1, 0, 2);
        check("R10 s_valid", 128'(s_valid), 1);
        check("R10 s_addr", 128'(s_addr), 128'(addr_of(2)));
        beat("R10 accept", 4'b0100, 4'b0, 1, 1, 2);
        // R8: idle then the parked master again, no wait cycle
        idle();
        @(negedge clk);
        check("R8 idle s_valid", 128'(s_valid), 0);
        check("R8 idle gnt", 128'(m_gnt), 0);
        beat("R8 parked", 4'b0100, 4'b0, 1, 1, 2);
        check("R8 same cycle valid", 128'(s_valid), 1);
        idle();
        @(negedge clk);
        check("R2 queue drained", 128'(expq.size()), 0);
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule